// File: doc/BRIEF.md
# Software Register-Access Command Channel

This block gives software a memory-mapped path for issuing one register read or one register write at a time to a slave on a serial power-management bus. Software first loads a 32-bit write-data register and then writes a command word that names the access class, the direction, a 4-bit slave identifier, a byte count and a 16-bit register address. The channel unpacks that word onto a downstream request port (valid/ready) and waits for the downstream response, which carries 32-bit read data.

A channel state machine reports its progress through a status register. A completed write returns the channel to idle on its own. A completed read latches the returned word and parks the channel in a wait-for-clear state until software writes the valid-clear register. Writes that arrive while the channel is busy are dropped and flagged with a sticky error bit. The register window of one channel is 0x40 bytes and is placed by a parameter.

Top module: `swcmd_channel`

## Requirements
- R1: After reset, status reads 0, the read-data register reads 0 and `dn_req_valid` is low.
- R2: Register offsets inside the window are: command +0x00, write data +0x04, read data +0x14, valid clear +0x24, status +0x28. A read returns data on the cycle after `reg_re`. Unmapped addresses and the valid-clear offset read as zero, and `reg_rdata` is zero in cycles with no read.
- R3: An accepted command word drives the request fields as follows: class = bits [31:30], write flag = bit 29 (1 = write), slave ID = bits [27:24], byte count minus one = bits [17:16], register address = bits [15:0]. `dn_req_wdata` carries the write-data register with byte 0 in bits [7:0].
- R4: Status bits [3:1] hold the state code: 0 idle, 1 request waiting for acceptance, 2 waiting for the response, 6 read data valid and waiting for a clear. A command write in idle moves the channel to code 1, and a request handshake moves it to code 2.
- R5: A response to a read latches `dn_rsp_rdata` into the read-data register and moves the channel to code 6.
- R6: A write of a value with bit 0 set to the valid-clear offset in code 6 returns the channel to idle. A valid-clear write in any other state, or with bit 0 clear, changes nothing.
- R7: A response to a write returns the channel directly to idle, with no valid-clear write.
- R8: A command or write-data write while the channel is not idle is ignored (the command, write data and request fields keep their values) and sets the sticky error flag in status bit 0.
- R9: Any write to the status offset clears the error flag.
- R10: While `dn_req_valid` is high and `dn_req_ready` is low, the request and all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_class | output | 2 | Access class from the command word |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_slave | output | 4 | Slave identifier |
| dn_req_len | output | 2 | Byte count minus one |
| dn_req_addr | output | 16 | Slave register address |
| dn_req_wdata | output | 32 | Write payload, little-endian packed |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | 32 | Downstream response read data |

## Verification
A downstream response and a software register write can land in the same clock edge. The bench provokes this twice. First, a command write is placed in the exact cycle in which a write response ends the transaction. That command must be judged against the busy state: it is rejected and flagged, while the channel still returns to idle. Second, a valid-clear write is placed in the cycle in which a read response arrives. The clear must be ignored because the channel is not yet in code 6, so the channel parks in code 6 with the new data latched. The outcome is then read back through the status, command and read-data registers.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;

  // Offsets inside one channel window (software depends on these)
  localparam int unsigned WIN_BITS = 6;
  localparam logic [WIN_BITS-1:0] OFS_CMD    = 6'h00;
  localparam logic [WIN_BITS-1:0] OFS_WDATA  = 6'h04;
  localparam logic [WIN_BITS-1:0] OFS_RDATA  = 6'h14;
  localparam logic [WIN_BITS-1:0] OFS_VCLR   = 6'h24;
  localparam logic [WIN_BITS-1:0] OFS_STATUS = 6'h28;

  typedef enum logic [2:0] {
    CH_IDLE   = 3'd0,
    CH_REQ    = 3'd1,
    CH_WAIT   = 3'd2,
    CH_VLDCLR = 3'd6
  } ch_state_e;

  typedef struct packed {
    logic [1:0]  cls;
    logic        is_write;
    logic [3:0]  slave;
    logic [1:0]  len_m1;
    logic [15:0] addr;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_cmd(input logic [31:0] w);
    cmd_fields_t f;
    f.cls      = w[31:30];
    f.is_write = w[29];
    f.slave    = w[27:24];
    f.len_m1   = w[17:16];
    f.addr     = w[15:0];
    return f;
  endfunction

  function automatic logic [31:0] status_word(input logic [2:0] code, input logic err);
    return {28'd0, code, err};
  endfunction

endpackage

// File: rtl/swcmd_regif.sv
module swcmd_regif
  import swcmd_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter logic [AW-1:0] BASE = 12'h080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   rb_cmd,
  input  logic [31:0]   rb_wdata,
  input  logic [31:0]   rb_rdata,
  input  logic [31:0]   rb_status,
  output logic          hit_cmd,
  output logic          hit_wdata,
  output logic          hit_vclr,
  output logic          hit_status,
  output logic [31:0]   reg_rdata
);

  logic                in_win;
  logic [WIN_BITS-1:0] offs;
  logic [31:0]         rd_mux;

  assign in_win = (reg_addr[AW-1:WIN_BITS] == BASE[AW-1:WIN_BITS]);
  assign offs   = reg_addr[WIN_BITS-1:0];

  assign hit_cmd    = reg_we && in_win && (offs == OFS_CMD);
  assign hit_wdata  = reg_we && in_win && (offs == OFS_WDATA);
  assign hit_vclr   = reg_we && in_win && (offs == OFS_VCLR);
  assign hit_status = reg_we && in_win && (offs == OFS_STATUS);

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (offs)
        OFS_CMD:    rd_mux = rb_cmd;
        OFS_WDATA:  rd_mux = rb_wdata;
        OFS_RDATA:  rd_mux = rb_rdata;
        OFS_STATUS: rd_mux = rb_status;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_re ? rd_mux : '0;
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_cmd, hit_wdata, hit_vclr, hit_status})); // R2
  AST_QUIET_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> reg_rdata == '0); // R2

endmodule

// File: rtl/swcmd_fsm.sv
module swcmd_fsm
  import swcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit_cmd,
  input  logic        hit_wdata,
  input  logic        hit_vclr,
  input  logic        hit_status,
  input  logic [31:0] wr_val,
  input  logic        dn_req_ready,
  input  logic        dn_rsp_valid,
  input  logic [31:0] dn_rsp_rdata,
  output logic [2:0]  state_code,
  output logic        err_q,
  output logic [31:0] cmd_q,
  output logic [31:0] wdata_q,
  output logic [31:0] rdata_q,
  output logic        dn_req_valid,
  output cmd_fields_t req_f
);

  ch_state_e state_q, state_d;

  // Named internal events
  logic is_idle, cmd_accept, busy_reject, rsp_take, rd_done, wr_done, clr_hit;

  assign req_f       = unpack_cmd(cmd_q);
  assign is_idle     = (state_q == CH_IDLE);
  assign cmd_accept  = hit_cmd && is_idle;
  assign busy_reject = (hit_cmd || hit_wdata) && !is_idle;
  assign rsp_take    = (state_q == CH_WAIT) && dn_rsp_valid;
  assign rd_done     = rsp_take && !req_f.is_write;
  assign wr_done     = rsp_take && req_f.is_write;
  assign clr_hit     = hit_vclr && (state_q == CH_VLDCLR) && wr_val[0];

  assign dn_req_valid = (state_q == CH_REQ);
  assign state_code   = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CH_IDLE:   if (cmd_accept)   state_d = CH_REQ;
      CH_REQ:    if (dn_req_ready) state_d = CH_WAIT;
      CH_WAIT:   if (rd_done)      state_d = CH_VLDCLR;
                 else if (wr_done) state_d = CH_IDLE;
      CH_VLDCLR: if (clr_hit)      state_d = CH_IDLE;
      default:                     state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      err_q   <= 1'b0;
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (busy_reject)     err_q <= 1'b1;
      else if (hit_status) err_q <= 1'b0;
      if (cmd_accept)              cmd_q   <= wr_val;
      if (hit_wdata && is_idle)    wdata_q <= wr_val;
      if (rd_done)                 rdata_q <= dn_rsp_rdata;
    end
  end

  AST_ACCEPT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> dn_req_valid && state_code == 3'd1); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(cmd_q) && $stable(wdata_q)); // R10
  AST_FIRE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && dn_req_ready |=> state_code == 3'd2); // R4
  AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> state_code == 3'd6 && rdata_q == $past(dn_rsp_rdata)); // R5
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> state_code == 3'd0); // R6
  AST_CLEAR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vclr && state_code == 3'd6 && !wr_val[0] |=> state_code == 3'd6); // R6
  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> state_code == 3'd0); // R7
  AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_reject |=> err_q && $stable(cmd_q) && $stable(wdata_q)); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_status |=> !err_q); // R9

endmodule

// File: rtl/swcmd_channel.sv
module swcmd_channel
  import swcmd_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter logic [AW-1:0] CHAN_BASE = 12'h080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [1:0]    dn_req_class,
  output logic          dn_req_write,
  output logic [3:0]    dn_req_slave,
  output logic [1:0]    dn_req_len,
  output logic [15:0]   dn_req_addr,
  output logic [31:0]   dn_req_wdata,
  input  logic          dn_rsp_valid,
  input  logic [31:0]   dn_rsp_rdata
);

  logic        hit_cmd, hit_wdata, hit_vclr, hit_status;
  logic [2:0]  state_code;
  logic        err_q;
  logic [31:0] cmd_q, wdata_q, rdata_q;
  cmd_fields_t req_f;

  swcmd_regif #(.AW(AW), .BASE(CHAN_BASE)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_addr   (reg_addr),
    .rb_cmd     (cmd_q),
    .rb_wdata   (wdata_q),
    .rb_rdata   (rdata_q),
    .rb_status  (status_word(state_code, err_q)),
    .hit_cmd    (hit_cmd),
    .hit_wdata  (hit_wdata),
    .hit_vclr   (hit_vclr),
    .hit_status (hit_status),
    .reg_rdata  (reg_rdata)
  );

  swcmd_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_cmd      (hit_cmd),
    .hit_wdata    (hit_wdata),
    .hit_vclr     (hit_vclr),
    .hit_status   (hit_status),
    .wr_val       (reg_wdata),
    .dn_req_ready (dn_req_ready),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_rdata (dn_rsp_rdata),
    .state_code   (state_code),
    .err_q        (err_q),
    .cmd_q        (cmd_q),
    .wdata_q      (wdata_q),
    .rdata_q      (rdata_q),
    .dn_req_valid (dn_req_valid),
    .req_f        (req_f)
  );

  assign dn_req_class = req_f.cls;
  assign dn_req_write = req_f.is_write;
  assign dn_req_slave = req_f.slave;
  assign dn_req_len   = req_f.len_m1;
  assign dn_req_addr  = req_f.addr;
  assign dn_req_wdata = wdata_q;

endmodule

// File: tb/swcmd_channel_tb.sv
module swcmd_channel_tb;

  localparam logic [11:0] B = 12'h080;
  localparam logic [11:0] A_CMD = B + 12'h00, A_WD = B + 12'h04, A_RD = B + 12'h14,
                          A_VC = B + 12'h24, A_ST = B + 12'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dn_req_valid, dn_req_ready = 0, dn_req_write;
  logic [1:0] dn_req_class, dn_req_len;
  logic [3:0] dn_req_slave;
  logic [15:0] dn_req_addr;
  logic [31:0] dn_req_wdata;
  logic dn_rsp_valid = 0;
  logic [31:0] dn_rsp_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swcmd_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dn_req_valid(dn_req_valid),
    .dn_req_ready(dn_req_ready), .dn_req_class(dn_req_class), .dn_req_write(dn_req_write),
    .dn_req_slave(dn_req_slave), .dn_req_len(dn_req_len), .dn_req_addr(dn_req_addr),
    .dn_req_wdata(dn_req_wdata), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
  );

  function automatic logic [31:0] mk_cmd(input logic [1:0] c, input logic w,
      input logic [3:0] s, input logic [1:0] l, input logic [15:0] a);
    return {c, w, 1'b0, s, 6'b0, l, a};
  endfunction

  function automatic logic [31:0] sts(input int code, input bit e);
    return (32'(code) << 1) | 32'(e);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  task automatic pulse_ready();
    @(negedge clk); dn_req_ready = 1;
    @(negedge clk); dn_req_ready = 0;
  endtask

  task automatic pulse_rsp(input logic [31:0] d);
    @(negedge clk); dn_rsp_valid = 1; dn_rsp_rdata = d;
    @(negedge clk); dn_rsp_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v); chk("R1 status", v, 0);
    rd(A_RD, v); chk("R1 rdata", v, 0);
    chk("R1 req_valid", 32'(dn_req_valid), 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_WD, 32'hA5A5_0F0F);
    rd(A_WD, v); chk("R2 wdata readback", v, 32'hA5A5_0F0F);
    rd(12'h100, v); chk("R2 unmapped", v, 0);
    rd(A_VC, v); chk("R2 vclr reads zero", v, 0);
    @(negedge clk); chk("R2 idle rdata", reg_rdata, 0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    wr(A_WD, 32'h1122_3344);
    wr(A_CMD, mk_cmd(2'd1, 1'b1, 4'd5, 2'd3, 16'h1234));
    chk("R3 valid", 32'(dn_req_valid), 1);
    chk("R3 class", 32'(dn_req_class), 1);
    chk("R3 write", 32'(dn_req_write), 1);
    chk("R3 slave", 32'(dn_req_slave), 5);
    chk("R3 len", 32'(dn_req_len), 3);
    chk("R3 addr", 32'(dn_req_addr), 32'h1234);
    chk("R3 wdata", dn_req_wdata, 32'h1122_3344);
    rd(A_ST, v); chk("R4 code 1", v, sts(1, 0));
    repeat (3) @(negedge clk);
    chk("R10 valid held", 32'(dn_req_valid), 1);
    chk("R10 addr held", 32'(dn_req_addr), 32'h1234);
    pulse_ready();
    chk("R4 valid drops", 32'(dn_req_valid), 0);
    rd(A_ST, v); chk("R4 code 2", v, sts(2, 0));
    pulse_rsp(32'hDEAD_0000);
    rd(A_ST, v); chk("R7 idle after write", v, sts(0, 0));
    rd(A_RD, v); chk("R7 rdata untouched", v, 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    wr(A_CMD, mk_cmd(2'd3, 1'b0, 4'hA, 2'd0, 16'h00FE));
    chk("R3 read flag", 32'(dn_req_write), 0);
    chk("R3 class 3", 32'(dn_req_class), 3);
    chk("R3 len 0", 32'(dn_req_len), 0);
    pulse_ready();
    pulse_rsp(32'hCAFE_BEEF);
    rd(A_ST, v); chk("R5 code 6", v, sts(6, 0));
    rd(A_RD, v); chk("R5 latched", v, 32'hCAFE_BEEF);
    wr(A_VC, 32'h0);
    rd(A_ST, v); chk("R6 bit0 clear ignored", v, sts(6, 0));
    wr(A_VC, 32'h1);
    rd(A_ST, v); chk("R6 cleared", v, sts(0, 0));
    wr(A_VC, 32'h1);
    rd(A_ST, v); chk("R6 clear in idle no effect", v, sts(0, 0));
  endtask

  task automatic t_busy();
    logic [31:0] v, c0;
    c0 = mk_cmd(2'd2, 1'b1, 4'd3, 2'd1, 16'h0042);
    wr(A_WD, 32'h0000_BEEF);
    wr(A_CMD, c0);
    wr(A_WD, 32'h5555_5555);
    wr(A_CMD, mk_cmd(2'd0, 1'b0, 4'd9, 2'd2, 16'h7777));
    rd(A_ST, v); chk("R8 error set", v, sts(1, 1));
    rd(A_CMD, v); chk("R8 cmd kept", v, c0);
    rd(A_WD, v); chk("R8 wdata kept", v, 32'h0000_BEEF);
    chk("R8 req addr kept", 32'(dn_req_addr), 32'h0042);
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk("R9 error cleared", v, sts(1, 0));
    pulse_ready();
    pulse_rsp('0);
  endtask

  task automatic t_collide();
    logic [31:0] v, c0;
    c0 = mk_cmd(2'd1, 1'b1, 4'd1, 2'd0, 16'h0010);
    wr(A_CMD, c0);
    pulse_ready();
    @(negedge clk);
    dn_rsp_valid = 1; reg_we = 1; reg_addr = A_CMD;
    reg_wdata = mk_cmd(2'd1, 1'b1, 4'd2, 2'd0, 16'h0020);
    @(negedge clk); dn_rsp_valid = 0; reg_we = 0;
    rd(A_ST, v); chk("R8 cmd rejected at completion", v, sts(0, 1));
    rd(A_CMD, v); chk("R8 old cmd kept", v, c0);
    wr(A_ST, 32'h0);
    wr(A_CMD, mk_cmd(2'd1, 1'b0, 4'd4, 2'd2, 16'h0030));
    pulse_ready();
    @(negedge clk);
    dn_rsp_valid = 1; dn_rsp_rdata = 32'h0BAD_F00D; reg_we = 1; reg_addr = A_VC; reg_wdata = 1;
    @(negedge clk); dn_rsp_valid = 0; reg_we = 0;
    rd(A_ST, v); chk("R6 early clear ignored", v, sts(6, 0));
    rd(A_RD, v); chk("R5 data with clash", v, 32'h0BAD_F00D);
    wr(A_VC, 32'h1);
    rd(A_ST, v); chk("R6 clear after clash", v, sts(0, 0));
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_write();
    t_read();
    t_busy();
    t_collide();
    report();
  end

endmodule